// File: doc/BRIEF.md
# Confidence-Gated PAM2 Symbol Detector

This block sits behind a time-interleaved ADC in a two-level serial receiver. Every clock it accepts one word that carries one signed ADC code per interleave lane (32 lanes of 6 bits by default). Each lane is compared against a programmable pair of thresholds that split the code range into three regions. If a code lies clearly above the band, the lane is resolved as '1'. If it lies clearly below the band, the lane is resolved as '0'. If it lies inside the band, the lane is marked as uncertain. For uncertain lanes only, the block raises a per-lane request that switches on the downstream digital equalizer for that one symbol.

The equalizer itself is outside this block. It sees the same input word, reads the request mask, and returns one decision bit per lane after a fixed number of clocks. The detector holds its own direct decisions in an alignment pipeline of matching depth. It then merges the equalizer's bits into the uncertain lanes, in lane order, and presents all lanes of one word together under a single output valid. A saturating counter totals the uncertain symbols, so that the share of equalizer activity can be monitored. The counter is a two-state machine. `CNT_RUN` accumulates and moves to `CNT_SAT` when the total reaches its maximum. `CNT_SAT` holds the maximum and returns to `CNT_RUN` only on a clear. A clear in `CNT_RUN` also stays in `CNT_RUN` with a zero total.

Top module: `conf_gate_detector`

## Requirements
- R1: Each lane code is two's complement, with lane i at `in_data[i*SW +: SW]` and reported on bit i of `eq_en`, `eq_bits` and `out_bits`. A code strictly greater than the upper threshold is decided '1' directly, and its `eq_en` bit stays 0.
- R2: A code strictly less than the lower threshold is decided '0' directly, and its `eq_en` bit stays 0.
- R3: A code with lower ≤ code ≤ upper (both ends inclusive) sets its `eq_en` bit. Its final `out_bits` bit is the matching `eq_bits` bit.
- R4: When the lower threshold is greater than the upper one, no lane is uncertain. Every lane is decided as '1' when code > upper and as '0' otherwise.
- R5: `eq_vld` and `eq_en` appear one clock edge after the word is sampled. `eq_vld` equals the delayed `in_valid`, and `eq_en` is all zeros whenever `eq_vld` is low.
- R6: `out_valid` and `out_bits` for a word appear LAT edges after its sampling edge. `eq_bits` is sampled on that same edge.
- R7: A pulse on `thr_we` loads `thr_lo_d` and `thr_hi_d`. The new values apply to words sampled on later edges. A word sampled on the write edge still uses the old thresholds.
- R8: For each valid word, `amb_count` grows by the number of uncertain lanes, one edge after that word's `eq_en` appears.
- R9: `cnt_clr` zeroes `amb_count` on the next edge and takes priority over a simultaneous increment.
- R10: `amb_count` saturates at 2^CNT_W−1 and holds there until it is cleared.
- R11: Reset clears `out_valid`, `eq_vld`, `eq_en` and `amb_count`, and sets both thresholds to 0. After reset, code 0 is therefore uncertain.
- R12: A cycle with `in_valid` low produces no output valid and adds nothing to the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_we | input | 1 | Threshold load strobe |
| thr_lo_d | input | SW | New lower threshold (signed) |
| thr_hi_d | input | SW | New upper threshold (signed) |
| cnt_clr | input | 1 | Clear uncertain-symbol counter |
| in_valid | input | 1 | Input word valid |
| in_data | input | LANES*SW | Lane codes, lane i at bits i*SW +: SW |
| eq_vld | output | 1 | Request mask valid |
| eq_en | output | LANES | Per-lane equalizer request |
| eq_bits | input | LANES | Equalizer decisions, sampled LAT edges after the input |
| out_valid | output | 1 | Merged decisions valid |
| out_bits | output | LANES | Final per-lane decisions |
| amb_count | output | CNT_W | Saturating count of uncertain symbols |

## Verification
The assertions check on every cycle that the request mask is silent without `eq_vld`, and that `eq_vld` follows `in_valid` by one edge. They also check that the counter never decreases or jumps by more than the lane count except through a clear, that a clear lands on the next edge, that a saturated count stays saturated, and that reset leaves the outputs quiet. Only the bench scenarios can show that each lane falls into the correct region, including the inclusive band edges and the inverted-threshold case. The same holds for the equalizer bits landing in the right lanes with the right latency, for threshold writes taking effect on the correct word, and for the counter reaching saturation and recovering after a clear.

// File: rtl/cgd_pkg.sv
package cgd_pkg;

    // Decision region of one lane code
    typedef enum logic [1:0] {
        REG_ZERO  = 2'd0,
        REG_AMBIG = 2'd1,
        REG_ONE   = 2'd2
    } region_e;

    // Uncertain-symbol counter states
    typedef enum logic {
        CNT_RUN = 1'b0,
        CNT_SAT = 1'b1
    } cnt_state_e;

endpackage

// File: rtl/cgd_slicer.sv
module cgd_slicer
    import cgd_pkg::*;
#(
    parameter int SW = 6
) (
    input  logic signed [SW-1:0] code,
    input  logic signed [SW-1:0] thr_lo,
    input  logic signed [SW-1:0] thr_hi,
    input  logic                 band_empty,
    output region_e              region
);

    always_comb begin
        if (band_empty) begin
            // inverted thresholds: plain slicer at the upper level
            region = (code > thr_hi) ? REG_ONE : REG_ZERO;
        end else if (code > thr_hi) begin
            region = REG_ONE;
        end else if (code < thr_lo) begin
            region = REG_ZERO;
        end else begin
            region = REG_AMBIG;
        end
    end

endmodule

// File: rtl/cgd_align_pipe.sv
module cgd_align_pipe #(
    parameter int LANES = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [LANES-1:0] in_bits,
    input  logic [LANES-1:0] in_amb,
    output logic             head_vld,
    output logic [LANES-1:0] head_amb,
    output logic             tail_vld,
    output logic [LANES-1:0] tail_bits,
    output logic [LANES-1:0] tail_amb
);

    logic [DEPTH-1:0]            vld_q;
    logic [DEPTH-1:0][LANES-1:0] bits_q;
    logic [DEPTH-1:0][LANES-1:0] amb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= '0;
            bits_q <= '0;
            amb_q  <= '0;
        end else begin
            vld_q[0]  <= in_vld;
            bits_q[0] <= in_vld ? in_bits : '0;
            amb_q[0]  <= in_vld ? in_amb  : '0;
            for (int s = 1; s < DEPTH; s++) begin
                vld_q[s]  <= vld_q[s-1];
                bits_q[s] <= bits_q[s-1];
                amb_q[s]  <= amb_q[s-1];
            end
        end
    end

    assign head_vld  = vld_q[0];
    assign head_amb  = amb_q[0];
    assign tail_vld  = vld_q[DEPTH-1];
    assign tail_bits = bits_q[DEPTH-1];
    assign tail_amb  = amb_q[DEPTH-1];

endmodule

// File: rtl/cgd_amb_counter.sv
module cgd_amb_counter
    import cgd_pkg::*;
#(
    parameter int LANES = 32,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             word_vld,
    input  logic [LANES-1:0] amb_mask,
    output logic [CNT_W-1:0] count
);

    localparam int          PW      = $clog2(LANES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic [PW-1:0]    pop;
    logic [CNT_W:0]   sum;

    always_comb begin
        pop = '0;
        for (int i = 0; i < LANES; i++) begin
            pop = pop + PW'(amb_mask[i]);
        end
    end

    assign sum = {1'b0, count_q} + {{(CNT_W + 1 - PW){1'b0}}, pop};

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CNT_RUN;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        unique case (state_q)
            CNT_RUN: begin
                if (clr) begin
                    count_d = '0;
                end else if (word_vld) begin
                    if (sum >= {1'b0, CNT_MAX}) begin
                        count_d = CNT_MAX;
                        state_d = CNT_SAT;
                    end else begin
                        count_d = sum[CNT_W-1:0];
                    end
                end
            end
            CNT_SAT: begin
                if (clr) begin
                    count_d = '0;
                    state_d = CNT_RUN;
                end
            end
            default: begin
                state_d = CNT_RUN;
                count_d = '0;
            end
        endcase
    end

    assign count = count_q;

endmodule

// File: rtl/conf_gate_detector.sv
module conf_gate_detector
    import cgd_pkg::*;
#(
    parameter int LANES = 32,
    parameter int SW    = 6,
    parameter int LAT   = 4,
    parameter int CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  thr_we,
    input  logic [SW-1:0]         thr_lo_d,
    input  logic [SW-1:0]         thr_hi_d,
    input  logic                  cnt_clr,
    input  logic                  in_valid,
    input  logic [LANES*SW-1:0]   in_data,
    output logic                  eq_vld,
    output logic [LANES-1:0]      eq_en,
    input  logic [LANES-1:0]      eq_bits,
    output logic                  out_valid,
    output logic [LANES-1:0]      out_bits,
    output logic [CNT_W-1:0]      amb_count
);

    logic signed [SW-1:0] thr_lo_q, thr_hi_q;
    logic                 band_empty;
    region_e              lane_region [LANES];
    logic [LANES-1:0]     dir_bits, amb_mask;
    logic                 head_vld, tail_vld;
    logic [LANES-1:0]     head_amb, tail_bits, tail_amb;
    logic                 out_valid_q;
    logic [LANES-1:0]     out_bits_q;

    // threshold registers
    always_ff @(posedge clk) begin
        if (rst) begin
            thr_lo_q <= '0;
            thr_hi_q <= '0;
        end else if (thr_we) begin
            thr_lo_q <= thr_lo_d;
            thr_hi_q <= thr_hi_d;
        end
    end

    assign band_empty = (thr_lo_q > thr_hi_q);

    // per-lane three-region classification
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        cgd_slicer #(.SW(SW)) u_slicer (
            .code       (in_data[g*SW +: SW]),
            .thr_lo     (thr_lo_q),
            .thr_hi     (thr_hi_q),
            .band_empty (band_empty),
            .region     (lane_region[g])
        );
        assign dir_bits[g] = (lane_region[g] == REG_ONE);
        assign amb_mask[g] = (lane_region[g] == REG_AMBIG);
    end

    // latency-matching pipeline for direct decisions
    cgd_align_pipe #(.LANES(LANES), .DEPTH(LAT)) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .in_vld    (in_valid),
        .in_bits   (dir_bits),
        .in_amb    (amb_mask),
        .head_vld  (head_vld),
        .head_amb  (head_amb),
        .tail_vld  (tail_vld),
        .tail_bits (tail_bits),
        .tail_amb  (tail_amb)
    );

    assign eq_vld = head_vld;
    assign eq_en  = head_amb & {LANES{head_vld}};

    cgd_amb_counter #(.LANES(LANES), .CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (cnt_clr),
        .word_vld (head_vld),
        .amb_mask (head_amb),
        .count    (amb_count)
    );

    // merge equalizer decisions into uncertain lanes
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_q <= 1'b0;
            out_bits_q  <= '0;
        end else begin
            out_valid_q <= tail_vld;
            if (tail_vld) begin
                out_bits_q <= (tail_bits & ~tail_amb) | (eq_bits & tail_amb);
            end
        end
    end

    assign out_valid = out_valid_q;
    assign out_bits  = out_bits_q;

endmodule

// File: rtl/cgd_checker.sv
module cgd_checker #(
    parameter int LANES = 32,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             cnt_clr,
    input logic             eq_vld,
    input logic [LANES-1:0] eq_en,
    input logic             out_valid,
    input logic [CNT_W-1:0] amb_count
);

    logic rst_q;

    AST_EN_GATED: assert property (@(posedge clk) disable iff (rst)
        !eq_vld |-> eq_en == '0);  // R5

    AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> eq_vld);  // R5

    AST_REQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !eq_vld);  // R12

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> amb_count == '0);  // R9

    AST_CNT_MONO: assert property (@(posedge clk) disable iff (rst)
        !cnt_clr |=> amb_count >= $past(amb_count));  // R8

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !cnt_clr |=> (amb_count - $past(amb_count)) <= CNT_W'(LANES));  // R8

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (amb_count == {CNT_W{1'b1}} && !cnt_clr) |=> amb_count == {CNT_W{1'b1}});  // R10

    always @(posedge clk) begin
        rst_q <= rst;
        if (rst_q && !rst) begin
            AST_RESET_QUIET: assert (!out_valid && !eq_vld && amb_count == '0);  // R11
        end
    end

endmodule

bind conf_gate_detector cgd_checker #(.LANES(LANES), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .cnt_clr   (cnt_clr),
    .eq_vld    (eq_vld),
    .eq_en     (eq_en),
    .out_valid (out_valid),
    .amb_count (amb_count)
);

// File: tb/tb_conf_gate_detector.sv
module tb_conf_gate_detector;

    localparam int LANES = 32;
    localparam int SW    = 6;
    localparam int LAT   = 3;
    localparam int CW    = 8;
    localparam int NC    = 2300;
    localparam int CMAX  = (1 << CW) - 1;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                thr_we = 1'b0;
    logic [SW-1:0]       thr_lo_d = '0, thr_hi_d = '0;
    logic                cnt_clr = 1'b0;
    logic                in_valid = 1'b0;
    logic [LANES*SW-1:0] in_data = '0;
    logic                eq_vld;
    logic [LANES-1:0]    eq_en;
    logic [LANES-1:0]    eq_bits = '0;
    logic                out_valid;
    logic [LANES-1:0]    out_bits;
    logic [CW-1:0]       amb_count;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    logic                vin  [NC];
    logic                clrv [NC];
    logic [LANES-1:0]    ambv [NC];
    logic [LANES-1:0]    dirv [NC];
    logic [LANES-1:0]    eqv  [NC];
    logic signed [SW-1:0] cur_lo = '0, cur_hi = '0;
    int                  cnt_model = 0;

    always #10 clk = ~clk;  // 50 MHz

    conf_gate_detector #(.LANES(LANES), .SW(SW), .LAT(LAT), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .thr_we(thr_we), .thr_lo_d(thr_lo_d), .thr_hi_d(thr_hi_d),
        .cnt_clr(cnt_clr), .in_valid(in_valid), .in_data(in_data),
        .eq_vld(eq_vld), .eq_en(eq_en), .eq_bits(eq_bits),
        .out_valid(out_valid), .out_bits(out_bits), .amb_count(amb_count)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // three-region decision per the requirements (R1..R4)
    function automatic void classify(input logic [LANES*SW-1:0] w,
                                     input logic signed [SW-1:0] lo,
                                     input logic signed [SW-1:0] hi,
                                     output logic [LANES-1:0] amb,
                                     output logic [LANES-1:0] dir);
        for (int i = 0; i < LANES; i++) begin
            logic signed [SW-1:0] s;
            s = w[i*SW +: SW];
            dir[i] = (s > hi);
            amb[i] = (lo <= hi) && (s >= lo) && (s <= hi);
        end
    endfunction

    function automatic logic [SW-1:0] clamp_code(input int v);
        if (v > 31) return SW'(31);
        if (v < -32) return SW'(-32);
        return SW'(v);
    endfunction

    function automatic logic [LANES*SW-1:0] fill(input int v);
        logic [LANES*SW-1:0] w;
        for (int i = 0; i < LANES; i++) w[i*SW +: SW] = clamp_code(v);
        return w;
    endfunction

    function automatic logic [LANES*SW-1:0] ramp(input int base);
        logic [LANES*SW-1:0] w;
        for (int i = 0; i < LANES; i++) w[i*SW +: SW] = clamp_code(base + i);
        return w;
    endfunction

    function automatic logic [LANES*SW-1:0] rand_word(input logic signed [SW-1:0] lo,
                                                     input logic signed [SW-1:0] hi);
        logic [LANES*SW-1:0] w;
        for (int i = 0; i < LANES; i++) begin
            int m, off;
            m   = int'($urandom % 4);
            off = int'($urandom % 5) - 2;
            if (m == 0)      w[i*SW +: SW] = SW'($urandom);
            else if (m == 1) w[i*SW +: SW] = clamp_code(int'(lo) + off);
            else if (m == 2) w[i*SW +: SW] = clamp_code(int'(hi) + off);
            else             w[i*SW +: SW] = clamp_code(int'($urandom % 9) - 4);
        end
        return w;
    endfunction

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state (R11)
        chk("R11 out_valid after reset", 64'(out_valid), 64'd0);
        chk("R11 eq_vld after reset", 64'(eq_vld), 64'd0);
        chk("R11 count after reset", 64'(amb_count), 64'd0);
        rst = 1'b0;

        for (int c = 0; c < NC; c++) begin
            logic [LANES*SW-1:0] w;
            logic                v, we, cl;
            logic signed [SW-1:0] nlo, nhi;
            if (c > 0) @(negedge clk);

            // ---- checks ----
            if (c >= 1) begin
                chk("R5 eq_vld follows in_valid", 64'(eq_vld), 64'(vin[c-1]));
                chk("R3 eq_en mask", 64'(eq_en), vin[c-1] ? 64'(ambv[c-1]) : 64'd0);
            end
            if (c >= LAT + 1) begin
                int k;
                k = c - LAT - 1;
                chk("R6/R12 out_valid latency", 64'(out_valid), 64'(vin[k]));
                if (vin[k])
                    chk("R1/R2/R3 merged out_bits",
                        64'(out_bits), 64'((dirv[k] & ~ambv[k]) | (eqv[c-1] & ambv[k])));
            end
            if (c >= 1) begin
                if (clrv[c-1]) cnt_model = 0;
                else if (c >= 2 && vin[c-2]) begin
                    cnt_model = cnt_model + $countones(ambv[c-2]);
                    if (cnt_model > CMAX) cnt_model = CMAX;
                end
            end
            chk("R8/R9/R10 amb_count", 64'(amb_count), 64'(cnt_model));

            // ---- stimulus ----
            v = 1'b1; we = 1'b0; cl = 1'b0; nlo = cur_lo; nhi = cur_hi;
            w = rand_word(cur_lo, cur_hi);
            if (c < 10) begin
                // R11: thresholds zero after reset, code 0 uncertain
                case (c % 5)
                    0: w = fill(0);
                    1: w = fill(-32);
                    2: w = fill(31);
                    3: w = ramp(-16);
                    default: v = 1'b0;  // R12 idle cycle
                endcase
            end else if (c == 10) begin
                // R7: word on the write edge uses old thresholds
                we = 1'b1; nlo = -3; nhi = 4; w = ramp(-16);
            end else if (c < 20) begin
                w = (c % 2 == 0) ? ramp(-6) : ramp(-20);  // band edges -3/4 inclusive
            end else if (c == 20) begin
                // R4: inverted thresholds
                we = 1'b1; nlo = 5; nhi = -5; w = ramp(-16);
            end else if (c < 30) begin
                w = (c % 2 == 0) ? ramp(-16) : fill(-5);
            end else if (c == 30) begin
                we = 1'b1; nlo = -31; nhi = 31; w = fill(0);
            end else if (c < 45) begin
                // all lanes uncertain: fast saturation (R10), then clear (R9)
                w = ramp(-16);
                if (c == 40) cl = 1'b1;
            end else if (c < NC - LAT - 4) begin
                if ($urandom % 8 == 0) v = 1'b0;
                if ($urandom % 40 == 0) begin
                    we  = 1'b1;
                    nlo = SW'(int'($urandom % 25) - 12);
                    nhi = SW'(int'($urandom % 25) - 12);
                end
                if ($urandom % 60 == 0) cl = 1'b1;
            end else begin
                v = 1'b0;
            end

            vin[c]  = v;
            clrv[c] = cl;
            eqv[c]  = LANES'($urandom);
            classify(w, cur_lo, cur_hi, ambv[c], dirv[c]);
            in_valid = v;
            in_data  = w;
            thr_we   = we;
            thr_lo_d = nlo;
            thr_hi_d = nhi;
            cnt_clr  = cl;
            eq_bits  = eqv[c];
            if (we) begin
                cur_lo = nlo;
                cur_hi = nhi;
            end
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule